// File: doc/BRIEF.md
# Configurable Two-Level AND-OR Logic Array

This block is a field-configurable sum-of-products array. It has eight dedicated inputs and ten bidirectional pins. Each bidirectional pin is split into three buses: the value seen at the pad, the computed data-out bit, and an output enable. All eighteen array inputs reach every product term in both true and complement form. Thirty-two logic terms can feed ten OR gates. Each OR gate is followed by a programmable inverter. Ten further control terms each set the direction of one bidirectional pin.

The configuration links are held in registers. They are loaded one word per address through a simple write port:

- Addresses 0 to 31 hold the AND links of the logic terms.
- Addresses 32 to 41 hold the AND links of the control terms.
- Addresses 42 to 51 hold the OR-row links, one row per output.
- Address 52 holds the polarity bits.

Evaluation of the array is purely combinational. A synchronous reset returns every link to its unprogrammed (intact) state.

Top module: `pla_sop_top`

## Requirements
- R1: While reset is held and on the first cycle after it, every output enable is 0 and every data-out bit is 0. All product terms are disabled, the outputs are non-inverting and all OR links are connected.
- R2: Array input k is dedicated input k for k = 0..7 and pad input k-8 for k = 8..17. In a term's AND word, bit 2k is the true link of input k and bit 2k+1 is its complement link, and 1 means intact. The link pair decodes as follows:
  - true only: the term requires the input to be 1.
  - complement only: the term requires the input to be 0.
  - both cleared: the input is a don't-care.
  - both intact: the term is forced to 0.
- R3: Writing address t (0..31) loads data bits 35:0 as the AND word of logic term t. Writing address 42+j loads data bits 31:0 as the OR row of output j, where bit t set connects logic term t. The sum for output j is the OR of its connected terms.
- R4: After reset, OR rows are fully connected. A logic term whose AND word is all don't-care therefore drives 1 onto every data-out bit until the OR rows are rewritten.
- R5: Writing address 52 loads data bits 9:0 as polarity. Bit j = 1 makes data-out j the complement of sum j, and bit j = 0 passes sum j unchanged.
- R6: Writing address 32+n loads the AND word of control term n. Output enable n equals that term's value. Data-out n is computed whether or not the enable is set.
- R7: Pad input values feed the array whatever the state of the output enables.
- R8: A write changes the outputs only from the clock edge that samples it. Writes to addresses above 52 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst | input | 1 | Synchronous active-high reset to the unprogrammed state |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration word address |
| cfgData | input | 36 | Configuration word data |
| dedIn | input | 8 | Dedicated array inputs |
| bioIn | input | 10 | Values present at the bidirectional pads |
| bioOut | output | 10 | Data driven onto each bidirectional pad when enabled |
| bioOe | output | 10 | Output enable per bidirectional pad |

## Verification
The bench walks one input through all four link-pair codes. A design with swapped true and complement bits, or one that treats the both-intact pair as a don't-care, would produce the wrong output or leave the term stuck. It checks that a don't-care term lights every output straight after reset, which exposes OR links that reset to disconnected. It also checks that a pad value feeds a term while that same pin's enable is high, which would fail in a design that gates feedback with direction. Writes to unused addresses and a look at the outputs just before the capturing edge catch decode aliasing and early updates. Random configurations are then compared against a behavioural reference.

// File: rtl/pla_sop_pkg.sv
package pla_sop_pkg;
  localparam int NUM_DED   = 8;
  localparam int NUM_BIO   = 10;
  localparam int NUM_LOGIC = 32;

  localparam int NUM_ARR   = NUM_DED + NUM_BIO;
  localparam int NUM_TERMS = NUM_LOGIC + NUM_BIO;
  localparam int AND_W     = 2 * NUM_ARR;
  localparam int DATA_W    = (AND_W > NUM_LOGIC) ? AND_W : NUM_LOGIC;

  localparam int CTRL_BASE = NUM_LOGIC;
  localparam int OR_BASE   = NUM_TERMS;
  localparam int POL_ADDR  = OR_BASE + NUM_BIO;
  localparam int NUM_ADDR  = POL_ADDR + 1;
  localparam int ADDR_W    = $clog2(NUM_ADDR);

  typedef struct packed {
    logic [NUM_TERMS-1:0] wrTerm;
    logic [NUM_BIO-1:0]   wrOrRow;
    logic                 wrPol;
  } cfg_strobe_t;
endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_sop_pkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output cfg_strobe_t       strobe
);
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    assign strobe.wrTerm[t] = cfgWe && (cfgAddr == ADDR_W'(t));
  end

  for (genvar j = 0; j < NUM_BIO; j++) begin : g_row
    assign strobe.wrOrRow[j] = cfgWe && (cfgAddr == ADDR_W'(OR_BASE + j));
  end

  assign strobe.wrPol = cfgWe && (cfgAddr == ADDR_W'(POL_ADDR));
endmodule

// File: rtl/pla_array_dp.sv
module pla_array_dp
  import pla_sop_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  cfg_strobe_t        strobe,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_BIO-1:0] bioIn,
  output logic [NUM_BIO-1:0] bioOut,
  output logic [NUM_BIO-1:0] bioOe
);
  logic [AND_W-1:0]     andLinks [NUM_TERMS];
  logic [NUM_LOGIC-1:0] orLinks  [NUM_BIO];
  logic [NUM_BIO-1:0]   polInv;
  logic [NUM_ARR-1:0]   arrIn;
  logic [NUM_TERMS-1:0] termVal;
  logic [NUM_BIO-1:0]   sumVal;

  // array input ordering: dedicated inputs low, pad feedback high
  assign arrIn = {bioIn, dedIn};

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [NUM_ARR-1:0] litOk;

    always_ff @(posedge clk) begin
      if (rst)                   andLinks[t] <= '1;
      else if (strobe.wrTerm[t]) andLinks[t] <= cfgData[AND_W-1:0];
    end

    // an intact link demands its literal; two intact links demand both
    for (genvar k = 0; k < NUM_ARR; k++) begin : g_lit
      assign litOk[k] = (~andLinks[t][2*k]   |  arrIn[k]) &
                        (~andLinks[t][2*k+1] | ~arrIn[k]);
    end

    assign termVal[t] = &litOk;
  end

  for (genvar j = 0; j < NUM_BIO; j++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)                    orLinks[j] <= '1;
      else if (strobe.wrOrRow[j]) orLinks[j] <= cfgData[NUM_LOGIC-1:0];
    end

    assign sumVal[j] = |(orLinks[j] & termVal[NUM_LOGIC-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)               polInv <= '0;
    else if (strobe.wrPol) polInv <= cfgData[NUM_BIO-1:0];
  end

  assign bioOut = sumVal ^ polInv;
  assign bioOe  = termVal[CTRL_BASE +: NUM_BIO];
endmodule

// File: rtl/pla_sop_top.sv
module pla_sop_top
  import pla_sop_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgData,
  input  logic [NUM_DED-1:0] dedIn,
  input  logic [NUM_BIO-1:0] bioIn,
  output logic [NUM_BIO-1:0] bioOut,
  output logic [NUM_BIO-1:0] bioOe
);
  cfg_strobe_t strobe;

  pla_cfg_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .strobe  (strobe)
  );

  pla_array_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cfgData (cfgData),
    .dedIn   (dedIn),
    .bioIn   (bioIn),
    .bioOut  (bioOut),
    .bioOe   (bioOe)
  );
endmodule

// File: rtl/pla_sop_chk.sv
module pla_sop_chk
  import pla_sop_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cfgWe,
  input logic [ADDR_W-1:0]  cfgAddr,
  input logic [DATA_W-1:0]  cfgData,
  input logic [NUM_DED-1:0] dedIn,
  input logic [NUM_BIO-1:0] bioIn,
  input logic [NUM_BIO-1:0] bioOut,
  input logic [NUM_BIO-1:0] bioOe
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE);
  localparam logic [ADDR_W-1:0] ORB_A  = ADDR_W'(OR_BASE);
  localparam logic [ADDR_W-1:0] POL_A  = ADDR_W'(POL_ADDR);

  logic ctrlWrite;
  assign ctrlWrite = cfgWe && (cfgAddr >= CTRL_A) && (cfgAddr < ORB_A);

  // R1: leaving reset, nothing is enabled and every output is low
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bioOe == '0) && (bioOut == '0));

  // R6: an all-don't-care control term enables its pin
  p_ctrl_enable_r6: assert property (@(posedge clk) disable iff (rst)
    ctrlWrite && (cfgData[AND_W-1:0] == '0) |=> bioOe[$past(cfgAddr) - CTRL_A]);

  // R2: both links of one input intact kill the control term
  p_both_intact_r2: assert property (@(posedge clk) disable iff (rst)
    ctrlWrite && (cfgData[1:0] == 2'b11) |=> !bioOe[$past(cfgAddr) - CTRL_A]);

  // R8: without a decoded write and with steady inputs, outputs hold
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(cfgWe && (cfgAddr <= POL_A)) |=>
      (!$stable(dedIn) || !$stable(bioIn) || ($stable(bioOut) && $stable(bioOe))));
endmodule

bind pla_sop_top pla_sop_chk u_chk (
  .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
  .dedIn(dedIn), .bioIn(bioIn), .bioOut(bioOut), .bioOe(bioOe)
);

// File: tb/tb_pla_sop_top.sv
module tb_pla_sop_top;
  import pla_sop_pkg::*;

  localparam time HALF = 10ns;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfgWe = 1'b0;
  logic [ADDR_W-1:0]  cfgAddr = '0;
  logic [DATA_W-1:0]  cfgData = '0;
  logic [NUM_DED-1:0] dedIn = '0;
  logic [NUM_BIO-1:0] bioIn = '0;
  logic [NUM_BIO-1:0] bioOut;
  logic [NUM_BIO-1:0] bioOe;

  int vecCount  = 0;
  int failCount = 0;

  logic [AND_W-1:0]     refAnd [NUM_TERMS];
  logic [NUM_LOGIC-1:0] refOr  [NUM_BIO];
  logic [NUM_BIO-1:0]   refPol;

  always #HALF clk = ~clk;

  pla_sop_top dut (.*);

  task automatic refReset();
    for (int t = 0; t < NUM_TERMS; t++) refAnd[t] = '1;
    for (int j = 0; j < NUM_BIO; j++) refOr[j] = '1;
    refPol = '0;
  endtask

  task automatic refWrite(input int a, input logic [DATA_W-1:0] d);
    if (a < NUM_TERMS) refAnd[a] = d[AND_W-1:0];
    else if (a < POL_ADDR) refOr[a - OR_BASE] = d[NUM_LOGIC-1:0];
    else if (a == POL_ADDR) refPol = d[NUM_BIO-1:0];
  endtask

  function automatic logic termRef(input int t);
    logic [NUM_ARR-1:0] x;
    logic v;
    x = {bioIn, dedIn};
    v = 1'b1;
    for (int k = 0; k < NUM_ARR; k++) begin
      case ({refAnd[t][2*k+1], refAnd[t][2*k]})
        2'b11: v = 1'b0;
        2'b01: v = v & x[k];
        2'b10: v = v & ~x[k];
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic check(input string req);
    logic [NUM_BIO-1:0] eo, ee;
    for (int j = 0; j < NUM_BIO; j++) begin
      logic s;
      s = 1'b0;
      for (int t = 0; t < NUM_LOGIC; t++) if (refOr[j][t] && termRef(t)) s = 1'b1;
      eo[j] = s ^ refPol[j];
      ee[j] = termRef(CTRL_BASE + j);
    end
    vecCount++;
    if (bioOut !== eo || bioOe !== ee) begin
      failCount++;
      $display("FAIL %s: out=%h exp=%h oe=%h exp=%h", req, bioOut, eo, bioOe, ee);
    end
  endtask

  task automatic drive(input logic [NUM_DED-1:0] d, input logic [NUM_BIO-1:0] b);
    dedIn = d;
    bioIn = b;
    #1;
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgAddr = ADDR_W'(a);
    cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    refWrite(a, d);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    refReset();
    repeat (3) @(negedge clk);
    #1;
    check("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    #1;
  endtask

  function automatic logic [AND_W-1:0] oneLit(input int k, input logic [1:0] code);
    logic [AND_W-1:0] w;
    w = '0;
    w[2*k +: 2] = code;
    return w;
  endfunction

  task automatic t_reset();
    doReset();
    drive('1, '1);
    check("R1 after reset");
    if (bioOut !== '0 || bioOe !== '0) begin
      failCount++;
      $display("FAIL R1: out=%h oe=%h exp=0 0", bioOut, bioOe);
    end
    vecCount++;
  endtask

  task automatic t_unprog_or();
    doReset();
    wr(5, '0);
    drive(8'h5a, 10'h0f0);
    check("R4 fully connected rows");
    if (bioOut !== '1) begin
      failCount++;
      $display("FAIL R4: out=%h exp=%h", bioOut, {NUM_BIO{1'b1}});
    end
    vecCount++;
  endtask

  task automatic t_link_codes();
    doReset();
    wr(OR_BASE, 36'h1);
    for (int c = 0; c < 4; c++) begin
      wr(0, oneLit(3, 2'(c)));
      drive(8'h00, '0); check("R2 link code input low");
      drive(8'h08, '0); check("R2 link code input high");
    end
    wr(0, oneLit(12, 2'b01));
    drive(8'h00, 10'h010); check("R2 pad literal true");
    drive(8'h00, 10'h000); check("R2 pad literal true low");
  endtask

  task automatic t_or_rows();
    doReset();
    wr(1, oneLit(0, 2'b01));
    wr(2, oneLit(1, 2'b10));
    wr(OR_BASE + 0, 36'h2);
    wr(OR_BASE + 1, 36'h4);
    wr(OR_BASE + 2, 36'h6);
    wr(OR_BASE + 3, 36'h0);
    for (int v = 0; v < 4; v++) begin
      drive(8'(v), '0);
      check("R3 OR row selection");
    end
  endtask

  task automatic t_polarity();
    doReset();
    wr(7, oneLit(2, 2'b01));
    wr(POL_ADDR, 36'h2a5);
    drive(8'h04, '0); check("R5 polarity term high");
    drive(8'h00, '0); check("R5 polarity term low");
  endtask

  task automatic t_direction();
    doReset();
    wr(CTRL_BASE + 3, '0);
    wr(CTRL_BASE + 6, oneLit(7, 2'b10));
    wr(4, '0);
    drive(8'h00, '0); check("R6 enables with inputs low");
    drive(8'h80, '0); check("R6 enables with input 7 high");
    wr(CTRL_BASE + 3, oneLit(0, 2'b11));
    check("R6 killed control term");
  endtask

  task automatic t_feedback();
    doReset();
    wr(CTRL_BASE + 4, '0);
    wr(0, oneLit(12, 2'b01));
    drive('0, 10'h010); check("R7 pad feedback while enabled high");
    drive('0, 10'h000); check("R7 pad feedback while enabled low");
  endtask

  task automatic t_ignore_timing();
    doReset();
    wr(9, '0);
    drive('0, '0);
    check("R8 baseline");
    @(negedge clk);
    cfgWe = 1'b1;
    cfgAddr = ADDR_W'(POL_ADDR);
    cfgData = 36'h3ff;
    #1;
    check("R8 before capturing edge");
    @(negedge clk);
    cfgWe = 1'b0;
    refWrite(POL_ADDR, 36'h3ff);
    #1;
    check("R8 after capturing edge");
    for (int a = NUM_ADDR; a < (1 << ADDR_W); a++) begin
      wr(a, '1);
      check("R8 unused address ignored");
    end
  endtask

  task automatic t_random();
    for (int cfgRun = 0; cfgRun < 12; cfgRun++) begin
      doReset();
      for (int t = 0; t < NUM_TERMS; t++) begin
        logic [AND_W-1:0] w;
        w = '0;
        for (int k = 0; k < NUM_ARR; k++) begin
          int r;
          r = $urandom_range(0, 19);
          if (r < 3) w[2*k] = 1'b1;
          else if (r < 6) w[2*k+1] = 1'b1;
          else if (r == 6 && $urandom_range(0, 3) == 0) w[2*k +: 2] = 2'b11;
        end
        wr(t, w);
      end
      for (int j = 0; j < NUM_BIO; j++) wr(OR_BASE + j, DATA_W'($urandom));
      wr(POL_ADDR, DATA_W'($urandom));
      for (int v = 0; v < 40; v++) begin
        drive(NUM_DED'($urandom), NUM_BIO'($urandom));
        check("R2 R3 random sum-of-products");
      end
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 150000);
    failCount++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    refReset();
    t_reset();
    t_unprog_or();
    t_link_codes();
    t_or_rows();
    t_polarity();
    t_direction();
    t_feedback();
    t_ignore_timing();
    t_random();
    finishRun();
  end
endmodule